// File: doc/BRIEF.md
# Multi-Window Inset Layout Generator

This block works out where the inset pictures of a multi-picture display fall. It runs on the display pixel clock. It counts pixels from the display line sync and lines from the display frame sync. For every pixel it reports four things: whether the pixel lies inside an inset, which inset it is, and the pixel's column and row inside that inset. A fast-blanking flag goes with these outputs, and the video mixer uses it to pick inset video in place of main video.

Every inset is half the active width and one third of the active height. Three tilings are offered. A single column of three insets can sit on the left or the right half. A two-column grid of six can have its column order mirrored. A second two-column grid of six has a fixed order. The mode, the side and the window offsets come from configuration inputs. They are captured only at a frame sync, so a layout never changes partway through a frame. With the default parameters the active area is 1408 pixels by 240 lines, inside a line of 1792 clocks.

Top module: `mpip_layout`

## Requirements
- R1: While rst_ni is low, and until the first frame sync after reset, in_inset_o, fbl_o, inset_idx_o, loc_x_o and loc_y_o are all 0. The captured mode resets to off.
- R2: The pixel count goes to 0 on the clock edge that sees a rising edge of hsync_i, and otherwise increments, saturating at its maximum. The line count goes to 0 on a rising edge of vsync_i, which takes priority. Otherwise it increments on each rising edge of hsync_i, saturating at its maximum.
- R3: A pixel is in the active window when h_ofs <= pixel < h_ofs + ACT_W and v_ofs <= line < v_ofs + ACT_H. A pixel outside the active window is never flagged.
- R4: Inset width is IW = ACT_W/2 and inset height is IH = ACT_H/3. Window lines at or beyond 3*IH are never flagged.
- R5: mode_i = 1 (single column) flags only the half selected by side_i (0 = left half, 1 = right half). The index is the row 0, 1 or 2, counted from the top.
- R6: mode_i = 2 (mirrorable grid) flags the whole window area as six insets. The index is 2*row + c, where c = physical column (0 left, 1 right) when side_i = 0, and c = 1 - column when side_i = 1.
- R7: mode_i = 3 (fixed grid) gives the mode 2 layout with side_i = 0, whatever the value of side_i.
- R8: For a flagged pixel, loc_x_o is the window column minus the inset's left edge and loc_y_o is the window row minus row*IH. When no inset is flagged, inset_idx_o, loc_x_o and loc_y_o are 0.
- R9: All outputs are registered. The outputs after a clock edge describe the pixel and line counts, and the captured configuration, held just before that edge.
- R10: fbl_o equals in_inset_o on every cycle.
- R11: mode_i = 0 (off) flags no pixel and holds fbl_o low.
- R12: mode_i, side_i, h_ofs_i and v_ofs_i are captured only on a rising edge of vsync_i. A change between frame syncs has no effect on the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Display pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Display line sync, active high |
| vsync_i | input | 1 | Display frame sync, active high |
| mode_i | input | 2 | 0 off, 1 single column, 2 mirrorable grid, 3 fixed grid |
| side_i | input | 1 | Column side / mirror select |
| h_ofs_i | input | H_CNT_W | Pixels from line sync to window start |
| v_ofs_i | input | V_CNT_W | Lines from frame sync to window start |
| in_inset_o | output | 1 | Pixel lies inside an inset |
| inset_idx_o | output | 3 | Inset index 0..5 |
| loc_x_o | output | H_CNT_W | Column inside the inset |
| loc_y_o | output | V_CNT_W | Row inside the inset |
| fbl_o | output | 1 | Fast-blanking: select inset video |

## Verification
A wrong pixel or line count, or a wrong captured configuration, shows up at the ports as a misplaced inset edge. It appears one clock after the first pixel affected, and every following pixel on that line and in that frame carries the error. The bench runs a behavioural model that advances cycle by cycle. It compares every output on every cycle, so an error is caught on the cycle it first appears. Directed checks are tied to frame positions: the first window pixel, a pixel two columns in, and a pixel in the bottom row after a configuration change mid-frame.

// File: rtl/mpip_pkg.sv
package mpip_pkg;
  localparam int NUM_ROWS = 3;
  localparam int NUM_COLS = 2;

  typedef enum logic [1:0] {
    MODE_OFF       = 2'd0,
    MODE_COL3      = 2'd1,
    MODE_GRID6     = 2'd2,
    MODE_GRID6_FIX = 2'd3
  } mpip_mode_e;
endpackage

// File: rtl/mpip_timing.sv
module mpip_timing #(
  parameter int H_CNT_W = 11,
  parameter int V_CNT_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hsync_i,
  input  logic               vsync_i,
  output logic [H_CNT_W-1:0] h_cnt_o,
  output logic [V_CNT_W-1:0] v_cnt_o,
  output logic               vs_rise_o
);
  localparam logic [H_CNT_W-1:0] H_MAX = '1;
  localparam logic [V_CNT_W-1:0] V_MAX = '1;

  logic hs_q, vs_q, hs_rise;

  assign hs_rise   = hsync_i & ~hs_q;
  assign vs_rise_o = vsync_i & ~vs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q    <= 1'b0;
      vs_q    <= 1'b0;
      h_cnt_o <= '0;
      v_cnt_o <= '0;
    end else begin
      hs_q <= hsync_i;
      vs_q <= vsync_i;
      if (hs_rise)              h_cnt_o <= '0;
      else if (h_cnt_o != H_MAX) h_cnt_o <= h_cnt_o + 1'b1;
      if (vs_rise_o)                       v_cnt_o <= '0;
      else if (hs_rise && v_cnt_o != V_MAX) v_cnt_o <= v_cnt_o + 1'b1;
    end
  end

  // R2: pixel count restarts after a line sync edge
  p_hrestart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_rise |=> (h_cnt_o == '0));

  // R2: line count restarts after a frame sync edge
  p_vrestart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_rise_o |=> (v_cnt_o == '0));
endmodule

// File: rtl/mpip_cfg.sv
module mpip_cfg
  import mpip_pkg::*;
#(
  parameter int H_CNT_W = 11,
  parameter int V_CNT_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vs_rise_i,
  input  logic [1:0]         mode_i,
  input  logic               side_i,
  input  logic [H_CNT_W-1:0] h_ofs_i,
  input  logic [V_CNT_W-1:0] v_ofs_i,
  output mpip_mode_e         mode_o,
  output logic               side_o,
  output logic [H_CNT_W-1:0] h_ofs_o,
  output logic [V_CNT_W-1:0] v_ofs_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o  <= MODE_OFF;
      side_o  <= 1'b0;
      h_ofs_o <= '0;
      v_ofs_o <= '0;
    end else if (vs_rise_i) begin
      mode_o  <= mpip_mode_e'(mode_i);
      side_o  <= side_i;
      h_ofs_o <= h_ofs_i;
      v_ofs_o <= v_ofs_i;
    end
  end

  // R12: configuration only moves at a frame sync edge
  p_cfg_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vs_rise_i |=> ($stable(mode_o) && $stable(side_o) &&
                    $stable(h_ofs_o) && $stable(v_ofs_o)));
endmodule

// File: rtl/mpip_tile.sv
module mpip_tile
  import mpip_pkg::*;
#(
  parameter int ACT_W   = 1408,
  parameter int ACT_H   = 240,
  parameter int H_CNT_W = 11,
  parameter int V_CNT_W = 10
) (
  input  logic [H_CNT_W-1:0] h_cnt_i,
  input  logic [V_CNT_W-1:0] v_cnt_i,
  input  logic [H_CNT_W-1:0] h_ofs_i,
  input  logic [V_CNT_W-1:0] v_ofs_i,
  input  mpip_mode_e         mode_i,
  input  logic               side_i,
  output logic               hit_o,
  output logic [2:0]         idx_o,
  output logic [H_CNT_W-1:0] lx_o,
  output logic [V_CNT_W-1:0] ly_o
);
  localparam int IW = ACT_W / NUM_COLS;
  localparam int IH = ACT_H / NUM_ROWS;
  localparam logic [H_CNT_W-1:0] AW   = H_CNT_W'(ACT_W);
  localparam logic [V_CNT_W-1:0] AH   = V_CNT_W'(ACT_H);
  localparam logic [H_CNT_W-1:0] IW_C = H_CNT_W'(IW);
  localparam logic [V_CNT_W-1:0] TILE_H = V_CNT_W'(NUM_ROWS * IH);

  logic [H_CNT_W-1:0] ax;
  logic [V_CNT_W-1:0] ay;
  logic               act, in_rows, pc, lc, col_ok;
  logic [NUM_ROWS-1:0] row_ge;
  logic [V_CNT_W-1:0]  row_base [NUM_ROWS];
  logic [1:0]          row;

  assign ax  = h_cnt_i - h_ofs_i;
  assign ay  = v_cnt_i - v_ofs_i;
  assign act = (h_cnt_i >= h_ofs_i) && (ax < AW) &&
               (v_cnt_i >= v_ofs_i) && (ay < AH);
  assign in_rows = ay < TILE_H;

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    assign row_base[r] = V_CNT_W'(r * IH);
    assign row_ge[r]   = ay >= row_base[r];
  end

  always_comb begin
    row = 2'd0;
    for (int r = 1; r < NUM_ROWS; r++)
      if (row_ge[r]) row = 2'(r);
  end

  assign pc = ax >= IW_C;
  // mirrored column order only in the mirrorable grid
  assign lc = pc ^ ((mode_i == MODE_GRID6) & side_i);
  assign col_ok = (mode_i != MODE_COL3) || (pc == side_i);

  assign hit_o = act && in_rows && row_ge[0] && (mode_i != MODE_OFF) && col_ok;

  always_comb begin
    idx_o = '0;
    lx_o  = '0;
    ly_o  = '0;
    if (hit_o) begin
      idx_o = (mode_i == MODE_COL3) ? {1'b0, row} : {row, lc};
      lx_o  = pc ? (ax - IW_C) : ax;
      ly_o  = ay - row_base[row];
    end
  end
endmodule

// File: rtl/mpip_layout.sv
module mpip_layout
  import mpip_pkg::*;
#(
  parameter int ACT_W   = 1408,
  parameter int ACT_H   = 240,
  parameter int H_CNT_W = 11,
  parameter int V_CNT_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hsync_i,
  input  logic               vsync_i,
  input  logic [1:0]         mode_i,
  input  logic               side_i,
  input  logic [H_CNT_W-1:0] h_ofs_i,
  input  logic [V_CNT_W-1:0] v_ofs_i,
  output logic               in_inset_o,
  output logic [2:0]         inset_idx_o,
  output logic [H_CNT_W-1:0] loc_x_o,
  output logic [V_CNT_W-1:0] loc_y_o,
  output logic               fbl_o
);
  localparam int IW = ACT_W / NUM_COLS;
  localparam int IH = ACT_H / NUM_ROWS;

  logic [H_CNT_W-1:0] h_cnt, h_ofs_q, lx;
  logic [V_CNT_W-1:0] v_cnt, v_ofs_q, ly;
  logic               vs_rise, side_q, hit;
  logic [2:0]         idx;
  mpip_mode_e         mode_q;

  mpip_timing #(.H_CNT_W(H_CNT_W), .V_CNT_W(V_CNT_W)) u_timing (
    .clk_i, .rst_ni, .hsync_i, .vsync_i,
    .h_cnt_o(h_cnt), .v_cnt_o(v_cnt), .vs_rise_o(vs_rise)
  );

  mpip_cfg #(.H_CNT_W(H_CNT_W), .V_CNT_W(V_CNT_W)) u_cfg (
    .clk_i, .rst_ni, .vs_rise_i(vs_rise),
    .mode_i, .side_i, .h_ofs_i, .v_ofs_i,
    .mode_o(mode_q), .side_o(side_q), .h_ofs_o(h_ofs_q), .v_ofs_o(v_ofs_q)
  );

  mpip_tile #(.ACT_W(ACT_W), .ACT_H(ACT_H), .H_CNT_W(H_CNT_W), .V_CNT_W(V_CNT_W)) u_tile (
    .h_cnt_i(h_cnt), .v_cnt_i(v_cnt), .h_ofs_i(h_ofs_q), .v_ofs_i(v_ofs_q),
    .mode_i(mode_q), .side_i(side_q),
    .hit_o(hit), .idx_o(idx), .lx_o(lx), .ly_o(ly)
  );

  // one register stage, aligned with the video path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_inset_o  <= 1'b0;
      fbl_o       <= 1'b0;
      inset_idx_o <= '0;
      loc_x_o     <= '0;
      loc_y_o     <= '0;
    end else begin
      in_inset_o  <= hit;
      fbl_o       <= hit;
      inset_idx_o <= idx;
      loc_x_o     <= lx;
      loc_y_o     <= ly;
    end
  end

  // R10
  p_fbl_match_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fbl_o == in_inset_o);

  // R3: left of window never flagged on the next cycle
  p_left_of_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_cnt < h_ofs_q) |=> !in_inset_o);

  // R11
  p_off_blank_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_OFF) |=> !fbl_o);

  // R5
  p_col3_idx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_COL3) |=> (inset_idx_o < 3'd3));

  // R6
  p_idx_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_inset_o |-> (inset_idx_o <= 3'd5));

  // R8
  p_loc_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_inset_o |-> ((loc_x_o < H_CNT_W'(IW)) && (loc_y_o < V_CNT_W'(IH))));

  p_idle_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_inset_o |-> (inset_idx_o == '0 && loc_x_o == '0 && loc_y_o == '0));
endmodule

// File: tb/sim_mpip_layout.sv
module sim_mpip_layout;
  localparam int ACT_W = 16;
  localparam int ACT_H = 12;
  localparam int HW = 6;
  localparam int VW = 5;
  localparam int LINE = 24;
  localparam int LINES = 18;
  localparam int IW = ACT_W / 2;
  localparam int IH = ACT_H / 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_i = 1'b0, vsync_i = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic side_i = 1'b0;
  logic [HW-1:0] h_ofs_i = '0;
  logic [VW-1:0] v_ofs_i = '0;
  logic in_inset_o, fbl_o;
  logic [2:0] inset_idx_o;
  logic [HW-1:0] loc_x_o;
  logic [VW-1:0] loc_y_o;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  mpip_layout #(.ACT_W(ACT_W), .ACT_H(ACT_H), .H_CNT_W(HW), .V_CNT_W(VW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .hsync_i, .vsync_i, .mode_i, .side_i,
    .h_ofs_i, .v_ofs_i, .in_inset_o, .inset_idx_o, .loc_x_o, .loc_y_o, .fbl_o
  );

  // behavioural reference model
  int mh, mv, mhs, mvs, m_mode, m_side, m_hofs, m_vofs;
  int e_in, e_idx, e_lx, e_ly;
  string e_tag;

  always @(posedge clk) begin
    if (!rst_n) begin
      mh = 0; mv = 0; mhs = 0; mvs = 0;
      m_mode = 0; m_side = 0; m_hofs = 0; m_vofs = 0;
      e_in = 0; e_idx = 0; e_lx = 0; e_ly = 0; e_tag = "R1";
    end else begin
      int ax, ay, col, row, lc, hr, vr;
      ax = mh - m_hofs; ay = mv - m_vofs;
      col = ax / IW; row = ay / IH;
      e_in = 0; e_idx = 0; e_lx = 0; e_ly = 0;
      if (m_mode == 0) e_tag = "R11";
      else if (mh < m_hofs || ax >= ACT_W || mv < m_vofs || ay >= ACT_H) e_tag = "R3";
      else if (row >= 3) e_tag = "R4";
      else begin
        case (m_mode)
          1: begin e_tag = "R5"; if (col == m_side) begin e_in = 1; e_idx = row; end end
          2: begin e_tag = "R6"; lc = m_side ? 1 - col : col; e_in = 1; e_idx = 2*row + lc; end
          default: begin e_tag = "R7"; e_in = 1; e_idx = 2*row + col; end
        endcase
        if (e_in) begin e_lx = ax % IW; e_ly = ay % IH; end
      end
      hr = (hsync_i && !mhs) ? 1 : 0;
      vr = (vsync_i && !mvs) ? 1 : 0;
      mhs = hsync_i; mvs = vsync_i;
      if (vr) begin m_mode = mode_i; m_side = side_i; m_hofs = h_ofs_i; m_vofs = v_ofs_i; end
      if (hr) mh = 0; else if (mh != (1 << HW) - 1) mh = mh + 1;
      if (vr) mv = 0; else if (hr && mv != (1 << VW) - 1) mv = mv + 1;
    end
  end

  // per-cycle comparison (R9 timing alignment for every field)
  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (in_inset_o !== 1'(e_in)) begin
        n_fail++; $display("FAIL %s/R9 in_inset actual %0b expected %0d", e_tag, in_inset_o, e_in);
      end
      if (inset_idx_o !== 3'(e_idx)) begin
        n_fail++; $display("FAIL %s idx actual %0d expected %0d", e_tag, inset_idx_o, e_idx);
      end
      if (loc_x_o !== HW'(e_lx) || loc_y_o !== VW'(e_ly)) begin
        n_fail++; $display("FAIL R8 loc actual %0d,%0d expected %0d,%0d", loc_x_o, loc_y_o, e_lx, e_ly);
      end
      if (fbl_o !== 1'(e_in)) begin
        n_fail++; $display("FAIL R10 fbl actual %0b expected %0d", fbl_o, e_in);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one frame with a configuration already captured; the next one is applied mid-frame
  task automatic run_frame(input int md, input int sd, input int ho, input int vo,
                           input int nmd, input int nsd, input int nho, input int nvo);
    int hit0, idx2;
    hit0 = (md != 0 && !(md == 1 && sd == 1)) ? 1 : 0;
    idx2 = (md == 0) ? 0 : (md == 1) ? 2 : (md == 2) ? 4 + sd : 4;
    if (!hit0) idx2 = 0;
    for (int l = 0; l < LINES; l++) begin
      for (int p = 0; p < LINE; p++) begin
        @(negedge clk);
        hsync_i = (p == 0);
        vsync_i = (l == 0 && p == 0);
        if (l == 9 && p == 0) begin
          mode_i = 2'(nmd); side_i = 1'(nsd); h_ofs_i = HW'(nho); v_ofs_i = VW'(nvo);
        end
        // output at this negedge reflects pixel count p-2
        if (l == vo && p == ho + 1) chk("R9 before window", int'(in_inset_o), 0);
        if (l == vo && p == ho + 2) chk("R9 first window pixel", int'(in_inset_o), hit0);
        if (l == vo && p == ho + 4) chk("R2 loc_x two in", int'(loc_x_o), hit0 ? 2 : 0);
        if (l == vo + 8 && p == ho + 3) begin
          chk("R12 held mode flag", int'(in_inset_o), hit0);
          chk("R12 held mode idx", int'(inset_idx_o), idx2);
        end
      end
    end
  endtask

  initial begin : wdog
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cm [9], cs [9], ch [9], cv [9];
    cm = '{0, 1, 1, 2, 2, 3, 3, 2, 0};
    cs = '{0, 0, 1, 0, 1, 0, 1, 0, 1};
    ch = '{3, 3, 5, 3, 0, 7, 3, 2, 3};
    cv = '{2, 2, 1, 3, 2, 5, 2, 1, 2};
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 in_inset reset", int'(in_inset_o), 0);
    chk("R1 fbl reset", int'(fbl_o), 0);
    chk("R1 loc reset", int'(loc_x_o) + int'(loc_y_o) + int'(inset_idx_o), 0);
    mode_i = 2'(cm[0]); side_i = 1'(cs[0]); h_ofs_i = HW'(ch[0]); v_ofs_i = VW'(cv[0]);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 off before first frame sync", int'(fbl_o), 0);
    for (int i = 0; i < 8; i++)
      run_frame(cm[i], cs[i], ch[i], cv[i], cm[i+1], cs[i+1], ch[i+1], cv[i+1]);
    run_frame(cm[8], cs[8], ch[8], cv[8], 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule